// File: doc/BRIEF.md
# Four-Requester Processor Bus Arbiter

This block decides which of four masters owns a shared processor bus. There are four requesters: the host bridge port, an external master port and two processors. The bridge always outranks everyone, and the external port comes second. The two processors share the lowest level. They are ordered either by a fixed rule or by a rotating one. When nobody asks for the bus, a park mode can hand it idle to one of the processors.

A configuration word chooses the processor ordering and the park mode. It also holds a debug option that removes grant overlap for chosen transfer types. A flattened transfer ends with a dead cycle in which no grant is active. The next owner is granted only after that cycle. Each transfer type can flatten always, or only when ownership is about to move to a different master. The surrounding logic supplies the bus activity, the end-of-transfer strobe and the transfer type.

Top module: `bus_arb4`

## Requirements
- R1: `gnt` is registered, is zero after reset and is never more than one-hot. Bit 0 is the bridge, bit 1 the external port, bit 2 processor A and bit 3 processor B.
- R2: At a decision point, a bridge request wins over all other requests.
- R3: At a decision point, an external request wins over both processor requests when the bridge is not requesting.
- R4: With `cfg_wdata[0]`=0 (fixed ordering), processor A wins every contest against processor B.
- R5: With `cfg_wdata[0]`=1 (rotating ordering), the processor that won the last A-versus-B contest loses the next one, and processor A is favoured after reset. A grant given to a lone processor request leaves the ordering unchanged.
- R6: A decision point is a cycle with `bus_busy`=0 or `xfer_end`=1. In every other cycle `gnt` keeps its value.
- R7: Park field `cfg_wdata[2:1]`: 0 means no parking (`gnt` is zero when there are no requests), 1 parks on processor A and 2 parks on processor B. The bridge and external ports are never parked.
- R8: Park field value 3 parks on the processor that last held a grant, which is processor A after reset.
- R9: Flatten enables sit in `cfg_wdata[7:4]`, one bit per transfer type (0 single read, 1 single write, 2 burst read, 3 burst write). When the bit for `xfer_kind` is set and its qualifier is clear, an end-of-transfer cycle with `bus_busy`=1 clears `gnt` for one cycle. Types whose enable bit is clear overlap: the new grant appears straight after the end-of-transfer cycle.
- R10: Qualifier bits sit in `cfg_wdata[11:8]`, one per transfer type. When both the qualifier and the enable for a type are set, the dead cycle is inserted only if the new grant differs from the current one.
- R11: `cfg_we` loads the configuration word at a clock edge. Its fields affect the decisions from the next edge on, and the word is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 4 | Requests: bridge, external, processor A, processor B (bit 0 upward) |
| bus_busy | input | 1 | A data tenure is in progress |
| xfer_end | input | 1 | Last cycle of the current data tenure |
| xfer_kind | input | 2 | Type of the ending transfer |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 12 | Configuration word |
| gnt | output | 4 | Registered one-hot grant |

## Verification
The hard case is an end-of-transfer cycle while new requests are waiting. In that cycle the normal overlapping handover and the flatten gap compete to decide the next grant. The bench keeps `bus_busy` high, raises `xfer_end` and drives each transfer type in turn. It checks for either a zero grant or the new owner one edge later. For the switch-qualified type it does this twice, once with the same owner still requesting and once with a different master requesting.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int NREQ   = 4;
    localparam int NKIND  = 4;
    localparam int KIND_W = $clog2(NKIND);

    localparam int IDX_HB   = 0;
    localparam int IDX_EXT  = 1;
    localparam int IDX_CPUA = 2;
    localparam int IDX_CPUB = 3;

    localparam int F_ROT   = 0;
    localparam int F_PARK  = 1;
    localparam int F_FLAT  = 4;
    localparam int F_QUAL  = F_FLAT + NKIND;
    localparam int CFG_W   = F_QUAL + NKIND;

    typedef enum logic [1:0] {
        PARK_OFF  = 2'd0,
        PARK_A    = 2'd1,
        PARK_B    = 2'd2,
        PARK_LAST = 2'd3
    } park_e;

    typedef struct packed {
        logic [NKIND-1:0] qual;
        logic [NKIND-1:0] flat;
        park_e            park;
        logic             rot;
    } arb_cfg_t;

    function automatic logic [NREQ-1:0] one_at(input int idx);
        logic [NREQ-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/arb_cfg_reg.sv
module arb_cfg_reg
    import arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output arb_cfg_t         cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            cfg.rot  <= wdata[F_ROT];
            cfg.park <= park_e'(wdata[F_PARK +: 2]);
            cfg.flat <= wdata[F_FLAT +: NKIND];
            cfg.qual <= wdata[F_QUAL +: NKIND];
        end
    end
endmodule

// File: rtl/arb_pick.sv
module arb_pick
    import arb_pkg::*;
(
    input  logic [NREQ-1:0] req,
    input  arb_cfg_t        cfg,
    input  logic            favour_b,
    input  logic            last_b,
    output logic [NREQ-1:0] pick,
    output logic            contest
);
    always_comb begin
        pick    = '0;
        contest = 1'b0;
        if (req[IDX_HB]) begin
            pick = one_at(IDX_HB);
        end else if (req[IDX_EXT]) begin
            pick = one_at(IDX_EXT);
        end else if (req[IDX_CPUA] && req[IDX_CPUB]) begin
            contest = 1'b1;
            pick = (cfg.rot && favour_b) ? one_at(IDX_CPUB) : one_at(IDX_CPUA);
        end else if (req[IDX_CPUA]) begin
            pick = one_at(IDX_CPUA);
        end else if (req[IDX_CPUB]) begin
            pick = one_at(IDX_CPUB);
        end else begin
            unique case (cfg.park)
                PARK_A:    pick = one_at(IDX_CPUA);
                PARK_B:    pick = one_at(IDX_CPUB);
                PARK_LAST: pick = last_b ? one_at(IDX_CPUB) : one_at(IDX_CPUA);
                default:   pick = '0;
            endcase
        end
    end
endmodule

// File: rtl/arb_pace.sv
module arb_pace
    import arb_pkg::*;
(
    input  logic              bus_busy,
    input  logic              xfer_end,
    input  logic [KIND_W-1:0] kind,
    input  arb_cfg_t          cfg,
    input  logic [NREQ-1:0]   pick,
    input  logic [NREQ-1:0]   gnt_now,
    output logic              upd,
    output logic [NREQ-1:0]   gnt_nxt
);
    logic gap;

    always_comb begin
        upd = !bus_busy || xfer_end;
        gap = bus_busy && xfer_end && cfg.flat[kind]
              && (!cfg.qual[kind] || (pick != gnt_now));
        gnt_nxt = gap ? '0 : pick;
    end
endmodule

// File: rtl/arb_track.sv
module arb_track
    import arb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            upd,
    input  logic            rot,
    input  logic            contest,
    input  logic [NREQ-1:0] gnt_nxt,
    output logic            favour_b,
    output logic            last_b
);
    always_ff @(posedge clk) begin
        if (rst) begin
            favour_b <= 1'b0;
            last_b   <= 1'b0;
        end else if (upd) begin
            if (gnt_nxt[IDX_CPUA]) last_b <= 1'b0;
            if (gnt_nxt[IDX_CPUB]) last_b <= 1'b1;
            if (rot && contest && (gnt_nxt[IDX_CPUA] || gnt_nxt[IDX_CPUB]))
                favour_b <= gnt_nxt[IDX_CPUA];
        end
    end
endmodule

// File: rtl/bus_arb4.sv
module bus_arb4
    import arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NREQ-1:0]   req,
    input  logic              bus_busy,
    input  logic              xfer_end,
    input  logic [KIND_W-1:0] xfer_kind,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [NREQ-1:0]   gnt
);
    arb_cfg_t        cfg_q;
    logic            favour_b;
    logic            last_b;
    logic [NREQ-1:0] pick;
    logic            contest;
    logic            upd;
    logic [NREQ-1:0] gnt_nxt;

    arb_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    arb_pick u_pick (
        .req      (req),
        .cfg      (cfg_q),
        .favour_b (favour_b),
        .last_b   (last_b),
        .pick     (pick),
        .contest  (contest)
    );

    arb_pace u_pace (
        .bus_busy (bus_busy),
        .xfer_end (xfer_end),
        .kind     (xfer_kind),
        .cfg      (cfg_q),
        .pick     (pick),
        .gnt_now  (gnt),
        .upd      (upd),
        .gnt_nxt  (gnt_nxt)
    );

    arb_track u_track (
        .clk      (clk),
        .rst      (rst),
        .upd      (upd),
        .rot      (cfg_q.rot),
        .contest  (contest),
        .gnt_nxt  (gnt_nxt),
        .favour_b (favour_b),
        .last_b   (last_b)
    );

    always_ff @(posedge clk) begin
        if (rst)      gnt <= '0;
        else if (upd) gnt <= gnt_nxt;
    end
endmodule

// File: rtl/arb_chk.sv
module arb_chk
    import arb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NREQ-1:0]   req,
    input logic              bus_busy,
    input logic              xfer_end,
    input logic [KIND_W-1:0] xfer_kind,
    input logic [NREQ-1:0]   gnt,
    input arb_cfg_t          cfg
);
    a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    a_r2_bridge_wins: assert property (@(posedge clk) disable iff (rst)
        (!bus_busy && req[IDX_HB]) |=> (gnt == one_at(IDX_HB)));

    a_r3_ext_second: assert property (@(posedge clk) disable iff (rst)
        (!bus_busy && !req[IDX_HB] && req[IDX_EXT]) |=> (gnt == one_at(IDX_EXT)));

    a_r4_fixed_a: assert property (@(posedge clk) disable iff (rst)
        (!bus_busy && !cfg.rot && req == 4'b1100) |=> (gnt == one_at(IDX_CPUA)));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_busy && !xfer_end) |=> $stable(gnt));

    a_r7_no_park: assert property (@(posedge clk) disable iff (rst)
        (!bus_busy && req == '0 && cfg.park == PARK_OFF) |=> (gnt == '0));

    a_r7_never_park_ports: assert property (@(posedge clk) disable iff (rst)
        (!bus_busy && !req[IDX_HB] && !req[IDX_EXT]) |=> (!gnt[IDX_HB] && !gnt[IDX_EXT]));

    a_r9_gap: assert property (@(posedge clk) disable iff (rst)
        (bus_busy && xfer_end && cfg.flat[xfer_kind] && !cfg.qual[xfer_kind]) |=> (gnt == '0));
endmodule

bind bus_arb4 arb_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .bus_busy  (bus_busy),
    .xfer_end  (xfer_end),
    .xfer_kind (xfer_kind),
    .gnt       (gnt),
    .cfg       (cfg_q)
);

// File: tb/tb_bus_arb4.sv
`timescale 1ns/1ps
module tb_bus_arb4;
    import arb_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NREQ-1:0]   req = '0;
    logic              bus_busy = 1'b0;
    logic              xfer_end = 1'b0;
    logic [KIND_W-1:0] xfer_kind = '0;
    logic              cfg_we = 1'b0;
    logic [CFG_W-1:0]  cfg_wdata = '0;
    logic [NREQ-1:0]   gnt;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bus_arb4 dut (
        .clk(clk), .rst(rst), .req(req), .bus_busy(bus_busy),
        .xfer_end(xfer_end), .xfer_kind(xfer_kind),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .gnt(gnt)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [NREQ-1:0] exp);
        checks++;
        if (gnt !== exp) begin
            errors++;
            $display("FAIL %s gnt=%b expected=%b", tag, gnt, exp);
        end
    endtask

    task automatic cfg_write(input logic [CFG_W-1:0] w);
        cfg_we = 1'b1;
        cfg_wdata = w;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        req = 4'b1111;
        tick();
        check("R1 reset", 4'b0000);
        rst = 1'b0;
        req = '0;
        tick();
        check("R7 R11 no park after reset", 4'b0000);
    endtask

    task automatic t_priority();
        req = 4'b1111; tick(); check("R2 bridge first", 4'b0001);
        req = 4'b1110; tick(); check("R3 external second", 4'b0010);
        req = 4'b1100; tick(); check("R4 fixed A", 4'b0100);
        tick();                check("R4 fixed A again", 4'b0100);
        req = 4'b1000; tick(); check("R4 lone B", 4'b1000);
        req = '0;      tick(); check("R7 idle no park", 4'b0000);
    endtask

    task automatic t_rotate();
        cfg_write(12'h001);
        tick();
        req = 4'b1100; tick(); check("R5 rot first A", 4'b0100);
        tick();                check("R5 rot then B", 4'b1000);
        tick();                check("R5 rot back A", 4'b0100);
        req = 4'b0100; tick(); check("R5 lone A", 4'b0100);
        req = 4'b1100; tick(); check("R5 lone win keeps order", 4'b1000);
        req = '0;
        cfg_write(12'h000);
        tick();
    endtask

    task automatic t_hold();
        req = 4'b0100; tick(); check("R6 setup", 4'b0100);
        bus_busy = 1'b1;
        req = 4'b0001; tick(); check("R6 hold while busy", 4'b0100);
        tick();                check("R6 still held", 4'b0100);
        xfer_end = 1'b1; xfer_kind = 2'd0;
        tick();                check("R6 overlap handover", 4'b0001);
        xfer_end = 1'b0; bus_busy = 1'b0; req = '0;
        tick();                check("R6 idle release", 4'b0000);
    endtask

    task automatic t_park();
        cfg_write(12'h002);
        check("R11 old cfg still used", 4'b0000);
        tick(); check("R7 park A", 4'b0100);
        cfg_write(12'h004); tick(); check("R7 park B", 4'b1000);
        cfg_write(12'h000); tick(); check("R7 park off", 4'b0000);
        cfg_write(12'h006); tick(); check("R8 park last is B", 4'b1000);
        req = 4'b0100; tick(); check("R8 grant A", 4'b0100);
        req = '0;      tick(); check("R8 park last is A", 4'b0100);
        cfg_write(12'h000); tick();
    endtask

    task automatic t_flat();
        cfg_write(12'h8C0);
        req = 4'b0100; tick(); check("R9 setup", 4'b0100);
        bus_busy = 1'b1; xfer_end = 1'b1; xfer_kind = 2'd2;
        tick(); check("R9 unconditional gap", 4'b0000);
        bus_busy = 1'b0; xfer_end = 1'b0;
        tick(); check("R9 regrant after gap", 4'b0100);
        bus_busy = 1'b1; xfer_end = 1'b1; xfer_kind = 2'd0; req = 4'b0010;
        tick(); check("R9 unflattened type overlaps", 4'b0010);
        bus_busy = 1'b0; xfer_end = 1'b0; req = 4'b0100;
        tick(); check("R10 setup", 4'b0100);
        bus_busy = 1'b1; xfer_end = 1'b1; xfer_kind = 2'd3;
        tick(); check("R10 same owner no gap", 4'b0100);
        req = 4'b0010;
        tick(); check("R10 switch gap", 4'b0000);
        bus_busy = 1'b0; xfer_end = 1'b0;
        tick(); check("R10 new owner after gap", 4'b0010);
        req = '0;
        cfg_write(12'h000); tick();
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_priority();
        t_rotate();
        t_hold();
        t_park();
        t_flat();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule